// File: doc/BRIEF.md
# ADC Conversion Queue Sequencer

This block walks a shared 64-entry table of conversion command words on behalf of two queues and hands one conversion at a time to an external converter. Each command word carries a channel number and a pause bit. Queue 1 runs from entry 0 up to a programmable boundary pointer. Queue 2 runs from that boundary pointer to the end of the table. A channel code of all ones ends a queue's pass early.

Software reaches the block through one register-style write port. Addresses 0 to 63 load table words as {pause, channel[5:0]}. Address 64 is the queue 1 control register and address 65 is the queue 2 control register, each laid out as {enable[3], mode[2:0]}. Address 66 holds the queue 2 boundary pointer. Address 67 is a command register: bits 0 and 1 clear the pause flags of queues 1 and 2, bits 2 and 3 clear their completion flags, and bits 4 and 5 are software triggers for queues 1 and 2. Each queue is started by software, by an edge on its own asynchronous trigger pin, or, for queue 2 only, by an interval-timer tick. Both queues share a single converter through a start/done handshake. Queue 1 is served first when both queues are ready.

Top module: `adc_queue_seq`

## Requirements
- R1: A word whose channel field is 63 is not converted. It ends the pass, sets that queue's completion flag, and in single-scan mode returns the status to idle (status codes: 0 idle, 1 armed, 2 active, 3 paused).
- R2: Queue 1 never converts the entry at the boundary pointer or any entry beyond it. Reaching that entry ends queue 1's pass in the same way as code 63.
- R3: When a word is an end-of-queue, either by code 63 or by the boundary, and also has its pause bit (bit 6) set, the end wins. Nothing is converted, the pause flag stays clear and the completion flag is set.
- R4: An ordinary word with its pause bit set is converted. The queue then goes to status 3 with its pause flag set, and it issues no further conversion until it resumes. The following word, even an end-of-queue, is handled only after resumption.
- R5: A paused queue resumes on its next qualifying event. Pause flags and completion flags clear only when a one is written to their command bits.
- R6: The mode encodings are 0 disabled, 1 software single-scan, 2 rising-edge single-scan, 3 falling-edge single-scan, 5/6/7 the continuous forms of 1/2/3. An edge mode starts only on its own edge polarity. A trigger mode waits in status 1 until the event arrives.
- R7: Mode 4 is interval-timer single-scan on queue 2, started by timer_tick from its boundary pointer. On queue 1, mode 4 is reserved.
- R8: A single-scan pass starts only if the enable bit was written as one. The enable bit clears itself when the pass ends, so no further event starts a new pass.
- R9: In the disabled mode or a reserved mode, the queue stays idle and ignores all triggers.
- R10: A continuous mode repeats the pass. An edge-triggered continuous queue returns to status 1 after each pass, sets its completion flag, and runs again on the next edge.
- R11: When both queues are ready at a word boundary, queue 1 is served first.
- R12: conv_start is a one-cycle pulse. No new conversion is issued until conv_done has returned for the previous one.
- R13: After reset, both statuses are idle, all flags are clear and conv_start is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register/table write strobe |
| wr_addr | input | 8 | Write address (table 0-63, registers 64-67) |
| wr_data | input | 8 | Write data |
| ext_trig_q1 | input | 1 | Asynchronous trigger for queue 1 |
| ext_trig_q2 | input | 1 | Asynchronous trigger for queue 2 |
| timer_tick | input | 1 | Interval-timer tick for queue 2 |
| conv_done | input | 1 | Converter finished the current conversion |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 6 | Channel to convert |
| conv_entry | output | 6 | Table entry of the request |
| conv_q2 | output | 1 | Request belongs to queue 2 |
| q1_status | output | 2 | Queue 1 status code |
| q2_status | output | 2 | Queue 2 status code |
| pause_flags | output | 2 | Pause flags, bit 0 queue 1 |
| done_flags | output | 2 | Completion flags, bit 0 queue 1 |

## Verification
Some properties can be checked on every cycle. Assertions cover these: no request ever carries channel 63, queue 1 stays below the boundary, at most one request is outstanding, grants are exclusive, an idle queue never issues, and a pause flag only rises on a converted word. Other behaviour needs the directed scenarios to show it. This includes the order of entries within a pass, end-over-pause precedence, resumption, the self-clearing enable, edge-polarity selection, timer starts, continuous repetition and the queue 1 priority order.

// File: rtl/adc_qseq_pkg.sv
package adc_qseq_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        QS_IDLE   = 2'd0,
        QS_ARMED  = 2'd1,
        QS_ACTIVE = 2'd2,
        QS_PAUSED = 2'd3
    } qstate_e;

    typedef enum logic [1:0] {
        EV_SW   = 2'd0,
        EV_RISE = 2'd1,
        EV_FALL = 2'd2,
        EV_TICK = 2'd3
    } evsrc_e;

    function automatic logic mode_valid(input logic [MODE_W-1:0] m, input logic has_timer);
        return (m != 3'd0) && ((m != 3'd4) || has_timer);
    endfunction

    function automatic logic mode_cont(input logic [MODE_W-1:0] m);
        return m >= 3'd5;
    endfunction

    function automatic evsrc_e mode_src(input logic [MODE_W-1:0] m);
        evsrc_e s;
        case (m)
            3'd1, 3'd5: s = EV_SW;
            3'd2, 3'd6: s = EV_RISE;
            3'd3, 3'd7: s = EV_FALL;
            default:    s = EV_TICK;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/adc_qseq_sync_edge.sv
module adc_qseq_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/adc_qseq_table.sv
module adc_qseq_table #(
    parameter int ENTRIES = 64,
    parameter int PTR_W   = 6,
    parameter int W       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] mem_q [ENTRIES];
    logic [W-1:0] mem_d [ENTRIES];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/adc_qseq_queue.sv
module adc_qseq_queue
    import adc_qseq_pkg::*;
#(
    parameter int PTR_W     = 6,
    parameter int CHAN_W    = 6,
    parameter bit HAS_TIMER = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [MODE_W-1:0] ctl_mode,
    input  logic              ctl_en,
    input  logic              sw_go,
    input  logic              clr_pause,
    input  logic              clr_done,
    input  logic              ext_rise,
    input  logic              ext_fall,
    input  logic              tick,
    input  logic [PTR_W-1:0]  start_ptr,
    input  logic [PTR_W:0]    end_ptr,
    input  logic              grant,
    input  logic              cw_pause,
    input  logic [CHAN_W-1:0] cw_chan,
    output logic              want,
    output logic [PTR_W-1:0]  ptr,
    output logic              issue,
    output logic [1:0]        status,
    output logic              pause_flag,
    output logic              done_flag
);
    localparam logic [CHAN_W-1:0] EOQ_CODE = '1;

    typedef struct packed {
        qstate_e           st;
        logic [MODE_W-1:0] mode;
        logic              en;
        logic [PTR_W:0]    ptr;
        logic              pflag;
        logic              dflag;
    } qreg_t;

    qreg_t  q_q, q_d;
    logic   evt, eoq, issue_c;
    evsrc_e src;

    always_comb begin
        src = mode_src(q_q.mode);
        case (src)
            EV_SW:   evt = sw_go;
            EV_RISE: evt = ext_rise;
            EV_FALL: evt = ext_fall;
            default: evt = tick;
        endcase
        eoq = (cw_chan == EOQ_CODE) || (q_q.ptr >= end_ptr);
    end

    always_comb begin
        q_d     = q_q;
        issue_c = 1'b0;
        if (clr_pause) q_d.pflag = 1'b0;
        if (clr_done)  q_d.dflag = 1'b0;
        if (ctl_we) begin
            q_d.mode = ctl_mode;
            q_d.en   = ctl_en;
            q_d.ptr  = {1'b0, start_ptr};
            if (mode_valid(ctl_mode, HAS_TIMER) && ctl_en)
                q_d.st = (mode_src(ctl_mode) == EV_SW) ? QS_ACTIVE : QS_ARMED;
            else
                q_d.st = QS_IDLE;
        end else begin
            case (q_q.st)
                QS_ARMED: begin
                    if (evt) begin
                        q_d.st  = QS_ACTIVE;
                        q_d.ptr = {1'b0, start_ptr};
                    end
                end
                QS_ACTIVE: begin
                    if (grant) begin
                        if (eoq) begin
                            q_d.dflag = 1'b1;
                            q_d.ptr   = {1'b0, start_ptr};
                            if (mode_cont(q_q.mode)) begin
                                q_d.st = (src == EV_SW) ? QS_ACTIVE : QS_ARMED;
                            end else begin
                                q_d.st = QS_IDLE;
                                q_d.en = 1'b0;
                            end
                        end else begin
                            issue_c = 1'b1;
                            q_d.ptr = q_q.ptr + 1'b1;
                            if (cw_pause) begin
                                q_d.st    = QS_PAUSED;
                                q_d.pflag = 1'b1;
                            end
                        end
                    end
                end
                QS_PAUSED: begin
                    if (evt) q_d.st = QS_ACTIVE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{st: QS_IDLE, mode: '0, en: 1'b0, ptr: '0, pflag: 1'b0, dflag: 1'b0};
        end else begin
            q_q <= q_d;
        end
    end

    assign want       = (q_q.st == QS_ACTIVE);
    assign ptr        = q_q.ptr[PTR_W-1:0];
    assign issue      = issue_c;
    assign status     = q_q.st;
    assign pause_flag = q_q.pflag;
    assign done_flag  = q_q.dflag;

    AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st == QS_IDLE) |-> !issue_c); // R9
    AST_PFLAG_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_q.pflag) |-> $past(issue_c)); // R3
    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st == QS_PAUSED && !evt && !ctl_we) |=> ($stable(q_q.ptr) && q_q.st == QS_PAUSED)); // R4
endmodule

// File: rtl/adc_queue_seq.sv
module adc_queue_seq
    import adc_qseq_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int CHAN_W  = 6,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int SYNC_N  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       ext_trig_q1,
    input  logic                       ext_trig_q2,
    input  logic                       timer_tick,
    input  logic                       conv_done,
    output logic                       conv_start,
    output logic [CHAN_W-1:0]          conv_chan,
    output logic [$clog2(ENTRIES)-1:0] conv_entry,
    output logic                       conv_q2,
    output logic [1:0]                 q1_status,
    output logic [1:0]                 q2_status,
    output logic [1:0]                 pause_flags,
    output logic [1:0]                 done_flags
);
    localparam int PTR_W = $clog2(ENTRIES);
    localparam int CW_W  = CHAN_W + 1;
    localparam int NQ    = 2;
    localparam logic [ADDR_W-1:0] A_CTL1 = ADDR_W'(ENTRIES);
    localparam logic [ADDR_W-1:0] A_CTL2 = ADDR_W'(ENTRIES + 1);
    localparam logic [ADDR_W-1:0] A_BND  = ADDR_W'(ENTRIES + 2);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(ENTRIES + 3);
    localparam logic [CHAN_W-1:0] EOQ_CODE = '1;

    typedef struct packed {
        logic              busy;
        logic              start;
        logic [CHAN_W-1:0] chan;
        logic [PTR_W-1:0]  entry;
        logic              q2;
        logic [PTR_W-1:0]  bnd;
    } top_t;

    top_t top_q, top_d;

    logic              tbl_we, cmd_we;
    logic [NQ-1:0]     ctl_we, trig_in, rise, fall, want, grant, issue;
    logic [NQ-1:0]     clr_pause, clr_done, sw_go, pflag, dflag;
    logic [PTR_W-1:0]  qptr [NQ];
    logic [1:0]        qst  [NQ];
    logic [PTR_W-1:0]  raddr;
    logic [CW_W-1:0]   rword;

    assign tbl_we    = wr_en && (wr_addr < A_CTL1);
    assign ctl_we[0] = wr_en && (wr_addr == A_CTL1);
    assign ctl_we[1] = wr_en && (wr_addr == A_CTL2);
    assign cmd_we    = wr_en && (wr_addr == A_CMD);
    assign trig_in   = {ext_trig_q2, ext_trig_q1};

    assign grant[0] = !top_q.busy && want[0];
    assign grant[1] = !top_q.busy && want[1] && !want[0];
    assign raddr    = grant[1] ? qptr[1] : qptr[0];

    adc_qseq_table #(.ENTRIES(ENTRIES), .PTR_W(PTR_W), .W(CW_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (wr_addr[PTR_W-1:0]),
        .wdata (wr_data[CW_W-1:0]),
        .raddr (raddr),
        .rdata (rword)
    );

    for (genvar g = 0; g < NQ; g++) begin : g_q
        logic [PTR_W-1:0] start_p;
        logic [PTR_W:0]   end_p;

        assign clr_pause[g] = cmd_we && wr_data[g];
        assign clr_done[g]  = cmd_we && wr_data[2+g];
        assign sw_go[g]     = cmd_we && wr_data[4+g];

        if (g == 0) begin : g_first
            assign start_p = '0;
            assign end_p   = {1'b0, top_q.bnd};
        end else begin : g_second
            assign start_p = top_q.bnd;
            assign end_p   = (PTR_W+1)'(ENTRIES);
        end

        adc_qseq_sync_edge #(.STAGES(SYNC_N)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (trig_in[g]),
            .rise     (rise[g]),
            .fall     (fall[g])
        );

        adc_qseq_queue #(.PTR_W(PTR_W), .CHAN_W(CHAN_W), .HAS_TIMER(g == 1)) u_queue (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctl_we     (ctl_we[g]),
            .ctl_mode   (wr_data[MODE_W-1:0]),
            .ctl_en     (wr_data[MODE_W]),
            .sw_go      (sw_go[g]),
            .clr_pause  (clr_pause[g]),
            .clr_done   (clr_done[g]),
            .ext_rise   (rise[g]),
            .ext_fall   (fall[g]),
            .tick       ((g == 1) ? timer_tick : 1'b0),
            .start_ptr  (start_p),
            .end_ptr    (end_p),
            .grant      (grant[g]),
            .cw_pause   (rword[CHAN_W]),
            .cw_chan    (rword[CHAN_W-1:0]),
            .want       (want[g]),
            .ptr        (qptr[g]),
            .issue      (issue[g]),
            .status     (qst[g]),
            .pause_flag (pflag[g]),
            .done_flag  (dflag[g])
        );
    end

    always_comb begin
        top_d       = top_q;
        top_d.start = |issue;
        if (wr_en && (wr_addr == A_BND)) top_d.bnd = wr_data[PTR_W-1:0];
        if (|issue) begin
            top_d.busy  = 1'b1;
            top_d.chan  = rword[CHAN_W-1:0];
            top_d.entry = raddr;
            top_d.q2    = grant[1];
        end else if (conv_done) begin
            top_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign conv_start  = top_q.start;
    assign conv_chan   = top_q.chan;
    assign conv_entry  = top_q.entry;
    assign conv_q2     = top_q.q2;
    assign q1_status   = qst[0];
    assign q2_status   = qst[1];
    assign pause_flags = pflag;
    assign done_flags  = dflag;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R12
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q.busy && !conv_done) |=> !conv_start); // R12
    AST_NO_EOQ_CONVERT: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (conv_chan != EOQ_CODE)); // R1
    AST_Q1_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !conv_q2) |-> (conv_entry < $past(top_q.bnd))); // R2
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R11
endmodule

// File: tb/adc_queue_seq_tb_top.sv
`timescale 1ns/1ps
module adc_queue_seq_tb_top;
    localparam real HALF = 2.5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       trig1 = 1'b0, trig2 = 1'b0, tick = 1'b0;
    logic       conv_done = 1'b0;
    logic       conv_start, conv_q2;
    logic [5:0] conv_chan, conv_entry;
    logic [1:0] q1_status, q2_status, pause_flags, done_flags;

    int tests = 0, fails = 0;
    int lg_q [64];
    int lg_e [64];
    int lg_c [64];
    int n_log = 0;
    int overlaps = 0;

    always #(HALF) clk = ~clk;

    adc_queue_seq dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ext_trig_q1(trig1), .ext_trig_q2(trig2), .timer_tick(tick), .conv_done(conv_done),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_entry(conv_entry),
        .conv_q2(conv_q2), .q1_status(q1_status), .q2_status(q2_status),
        .pause_flags(pause_flags), .done_flags(done_flags)
    );

    // converter model: logs each request, answers after four cycles
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && conv_start) begin
                if (n_log < 64) begin
                    lg_q[n_log] = conv_q2 ? 1 : 0;
                    lg_e[n_log] = int'(conv_entry);
                    lg_c[n_log] = int'(conv_chan);
                end
                n_log++;
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    if (conv_start) overlaps++;
                end
                conv_done = 1'b1;
                @(negedge clk);
                if (conv_start) overlaps++;
                conv_done = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_conv(input string req, input int idx, input int q, input int e, input int c);
        chk(req, $sformatf("conv[%0d] queue", idx), lg_q[idx], q);
        chk(req, $sformatf("conv[%0d] entry", idx), lg_e[idx], e);
        chk(req, $sformatf("conv[%0d] chan", idx), lg_c[idx], c);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_word(input int a, input int p, input int ch);
        wr(a, (p << 6) | ch);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiesce();
        wr(64, 0); wr(65, 0); wr(67, 8'h0F);
        idle(4);
        n_log = 0;
    endtask

    task automatic t_reset();
        chk("R13", "q1 status", int'(q1_status), 0);
        chk("R13", "q2 status", int'(q2_status), 0);
        chk("R13", "pause flags", int'(pause_flags), 0);
        chk("R13", "done flags", int'(done_flags), 0);
        chk("R13", "conv_start", int'(conv_start), 0);
    endtask

    task automatic t_sw_single();
        quiesce();
        wr_word(0, 0, 5); wr_word(1, 0, 6); wr_word(2, 0, 7); wr_word(3, 0, 63);
        wr(66, 32);
        wr(64, 8'h09);
        idle(100);
        chk("R1", "conv count", n_log, 3);
        chk_conv("R6", 0, 0, 0, 5);
        chk_conv("R6", 1, 0, 1, 6);
        chk_conv("R1", 2, 0, 2, 7);
        chk("R1", "done flag q1", int'(done_flags[0]), 1);
        chk("R1", "q1 status", int'(q1_status), 0);
        wr(67, 8'h10);
        idle(60);
        chk("R8", "enable self-cleared, no rerun", n_log, 3);
        wr(67, 8'h04);
        idle(2);
        chk("R5", "done flag cleared", int'(done_flags[0]), 0);
        n_log = 0;
        wr(64, 8'h01);
        idle(60);
        chk("R8", "no start without enable", n_log, 0);
        chk("R8", "q1 status", int'(q1_status), 0);
    endtask

    task automatic t_boundary();
        quiesce();
        wr_word(0, 0, 1); wr_word(1, 0, 2); wr_word(2, 0, 3); wr_word(3, 1, 4);
        wr(66, 3);
        wr(64, 8'h09);
        idle(100);
        chk("R2", "conv count at boundary", n_log, 3);
        chk_conv("R2", 2, 0, 2, 3);
        chk("R3", "pause flag at boundary", int'(pause_flags[0]), 0);
        chk("R3", "done flag", int'(done_flags[0]), 1);
    endtask

    task automatic t_pause_eoq();
        quiesce();
        wr_word(0, 0, 9); wr_word(1, 1, 63);
        wr(66, 32);
        wr(64, 8'h09);
        idle(80);
        chk("R3", "conv count", n_log, 1);
        chk("R3", "pause flag", int'(pause_flags[0]), 0);
        chk("R3", "done flag", int'(done_flags[0]), 1);
        chk("R3", "q1 status", int'(q1_status), 0);
    endtask

    task automatic t_pause_resume();
        quiesce();
        wr_word(0, 0, 10); wr_word(1, 1, 11); wr_word(2, 0, 63);
        wr(66, 32);
        wr(64, 8'h09);
        idle(100);
        chk("R4", "conv count", n_log, 2);
        chk_conv("R4", 1, 0, 1, 11);
        chk("R4", "q1 status paused", int'(q1_status), 3);
        chk("R4", "pause flag", int'(pause_flags[0]), 1);
        chk("R4", "done flag still clear", int'(done_flags[0]), 0);
        wr(67, 8'h10);
        idle(40);
        chk("R5", "no conversion after resume", n_log, 2);
        chk("R5", "done after resume", int'(done_flags[0]), 1);
        chk("R5", "q1 status idle", int'(q1_status), 0);
        chk("R5", "pause flag held", int'(pause_flags[0]), 1);
        wr(67, 8'h01);
        idle(2);
        chk("R5", "pause flag cleared", int'(pause_flags[0]), 0);
    endtask

    task automatic t_edges();
        quiesce();
        wr_word(0, 0, 20); wr_word(1, 0, 21); wr_word(2, 0, 63);
        wr(66, 32);
        wr(64, 8'h0A);
        idle(20);
        chk("R6", "rise mode armed", int'(q1_status), 1);
        chk("R6", "no conv before edge", n_log, 0);
        trig1 = 1'b1;
        idle(100);
        chk("R6", "rise conv count", n_log, 2);
        chk_conv("R6", 1, 0, 1, 21);
        trig1 = 1'b0;
        idle(20);
        n_log = 0;
        wr(64, 8'h0B);
        trig1 = 1'b1;
        idle(40);
        chk("R6", "fall mode ignores rise", n_log, 0);
        trig1 = 1'b0;
        idle(100);
        chk("R6", "fall conv count", n_log, 2);
        chk_conv("R6", 0, 0, 0, 20);
    endtask

    task automatic t_timer();
        quiesce();
        wr(66, 8);
        wr_word(8, 0, 30); wr_word(9, 0, 31); wr_word(10, 0, 63);
        wr(65, 8'h0C);
        idle(10);
        chk("R7", "q2 timer armed", int'(q2_status), 1);
        @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
        idle(100);
        chk("R7", "timer conv count", n_log, 2);
        chk_conv("R7", 0, 1, 8, 30);
        chk_conv("R7", 1, 1, 9, 31);
        chk("R7", "q2 done", int'(done_flags[1]), 1);
        quiesce();
        wr(64, 8'h0C);
        idle(4);
        chk("R7", "q1 timer mode reserved", int'(q1_status), 0);
        @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
        wr(67, 8'h10);
        trig1 = 1'b1; idle(10); trig1 = 1'b0;
        idle(40);
        chk("R9", "reserved ignores triggers", n_log, 0);
    endtask

    task automatic t_disabled();
        quiesce();
        wr_word(0, 0, 2); wr_word(1, 0, 63);
        wr(66, 32);
        wr(64, 8'h08);
        trig1 = 1'b1; idle(10); trig1 = 1'b0; idle(10);
        wr(67, 8'h10);
        idle(40);
        chk("R9", "disabled ignores triggers", n_log, 0);
        chk("R9", "disabled status", int'(q1_status), 0);
        wr(64, 8'h02);
        trig1 = 1'b1;
        idle(40);
        chk("R8", "edge without enable", n_log, 0);
        trig1 = 1'b0;
        idle(10);
    endtask

    task automatic t_continuous();
        quiesce();
        wr_word(0, 0, 40); wr_word(1, 0, 41); wr_word(2, 0, 63);
        wr(66, 32);
        wr(64, 8'h0E);
        trig1 = 1'b1;
        idle(100);
        chk("R10", "first pass count", n_log, 2);
        chk("R10", "re-armed", int'(q1_status), 1);
        chk("R10", "done flag", int'(done_flags[0]), 1);
        trig1 = 1'b0; idle(10); trig1 = 1'b1;
        idle(100);
        chk("R10", "second pass count", n_log, 4);
        chk_conv("R10", 2, 0, 0, 40);
        chk_conv("R10", 3, 0, 1, 41);
        trig1 = 1'b0;
        idle(10);
    endtask

    task automatic t_priority();
        quiesce();
        wr_word(0, 0, 50); wr_word(1, 0, 51); wr_word(2, 0, 52); wr_word(3, 0, 53);
        wr_word(4, 0, 54); wr_word(5, 0, 55); wr_word(6, 0, 63);
        wr(66, 4);
        wr(64, 8'h0A);
        wr(65, 8'h0A);
        @(negedge clk); trig1 = 1'b1; trig2 = 1'b1;
        idle(150);
        chk("R11", "total conv count", n_log, 6);
        for (int i = 0; i < 4; i++) chk_conv("R11", i, 0, i, 50 + i);
        chk_conv("R11", 4, 1, 4, 54);
        chk_conv("R11", 5, 1, 5, 55);
        trig1 = 1'b0; trig2 = 1'b0;
        idle(10);
    endtask

    initial begin
        #(HALF * 2 * 150000);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_sw_single();
        t_boundary();
        t_pause_eoq();
        t_pause_resume();
        t_edges();
        t_timer();
        t_disabled();
        t_continuous();
        t_priority();
        chk("R12", "overlapping requests", overlaps, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule